// File: doc/BRIEF.md
# SPI FIFO Command Port

This block is an SPI slave front end that lets a host reach a transmit FIFO and a receive FIFO through two streaming commands. The host lowers chip select and sends a one-byte opcode. One opcode turns the rest of the transaction into a burst of writes, and each complete byte is pushed into the transmit FIFO. The other opcode turns it into a burst of reads, and bytes are popped from the receive FIFO and shifted out on SDO for as long as the host keeps clocking.

The FIFOs are outside the block. It drives a push strobe with a data byte and a pop strobe, and it reads a full flag, an empty flag and the head-of-queue byte. The SPI pins are sampled in the system clock domain through two-flop synchronisers. The system clock must run at least four times faster than SCLK. Two sticky flags report a write dropped on a full FIFO and a read served from an empty FIFO. Both flags clear only on reset.

Top module: `spi_fifo_port`

## Requirements
- R1: SCLK, chip select and SDI pass through two synchronising flops. SDI is sampled on each rising SCLK edge, most significant bit first, and the first byte after chip select falls is taken as the opcode.
- R2: After opcode 0x66, each complete byte is presented on `tx_data` with a one-cycle `tx_push` pulse. The pulse comes in the cycle in which the byte's eighth rising edge is seen after synchronisation.
- R3: When `tx_full` is high at a byte boundary in write mode, that byte is not pushed and `ovf` goes high and stays high until reset.
- R4: After opcode 0x77, `rx_pop` pulses at the end of the opcode and at the end of every following byte, and the head byte is loaded at that moment. Its bits go out on `sdo` most significant bit first. `sdo` changes only after a falling SCLK edge, so the first bit is valid before the first rising edge of the next byte.
- R5: When `rx_empty` is high at a read-mode byte boundary, no pop is issued, the byte 0x00 is shifted out and `udf` goes high and stays high until reset.
- R6: Raising chip select ends the transaction, discards any partial byte and drives `sdo` to 0. The next transaction begins with opcode decode. If the release is seen in the same cycle as a byte's final rising edge, the release wins and the byte is dropped.
- R7: Any opcode other than 0x66 or 0x77 causes no push and no pop, and keeps `sdo` at 0 until chip select rises.
- R8: After reset, `sdo`, `tx_push`, `rx_pop`, `ovf` and `udf` are all 0.
- R9: The number of bytes read depends only on the clocks the host supplies. Reading N bytes pops N+1 entries, because one byte is fetched ahead at each boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | W | Byte to push |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | W | Receive FIFO head byte |
| rx_empty | input | 1 | Receive FIFO empty |
| ovf | output | 1 | Sticky overflow flag |
| udf | output | 1 | Sticky underflow flag |

## Verification
The release of chip select and the final rising SCLK edge of a byte can be seen in the same system clock cycle. When that happens, the block has to choose between completing the push and discarding the partial byte. The bench provokes this by driving the eighth rising edge of a data byte and the chip-select release at the same clock edge. The cycle model, and a check on the collected push log, then require the byte to be absent while the byte before it in the same burst is still pushed.

// File: rtl/spi_fifo_port.sv
`timescale 1ns/1ps
module spi_fifo_port #(
  parameter int W = 8,
  parameter logic [W-1:0] OP_WR = 8'h66,
  parameter logic [W-1:0] OP_RD = 8'h77
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         sdi,
  output logic         sdo,
  output logic         tx_push,
  output logic [W-1:0] tx_data,
  input  logic         tx_full,
  output logic         rx_pop,
  input  logic [W-1:0] rx_data,
  input  logic         rx_empty,
  output logic         ovf,
  output logic         udf
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {ST_OPC, ST_WR, ST_RD, ST_IGN} st_t;

  logic [2:0]    sck_q;
  logic [1:0]    cs_q, di_q;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [W-2:0]  in_sh;
  logic [W-1:0]  out_sh;

  // R1: synchronisers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      di_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[0], cs_n};
      di_q  <= {di_q[0], sdi};
    end

  logic sel, sck_r, sck_f, last, go_rd;
  logic [W-1:0] shift_byte;

  assign sel        = ~cs_q[1];
  assign sck_r      = sck_q[1] & ~sck_q[2];
  assign sck_f      = ~sck_q[1] & sck_q[2];
  assign shift_byte = {in_sh, di_q[1]};
  assign last       = sel & sck_r & (cnt == CW'(W-1));
  assign go_rd      = last & (((st == ST_OPC) & (shift_byte == OP_RD)) | (st == ST_RD));
  assign tx_data    = shift_byte;
  assign tx_push    = last & (st == ST_WR) & ~tx_full;
  assign rx_pop     = go_rd & ~rx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_OPC;
      cnt    <= '0;
      in_sh  <= '0;
      out_sh <= '0;
      sdo    <= 1'b0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else if (!sel) begin
      st  <= ST_OPC;
      cnt <= '0;
      sdo <= 1'b0;
    end else begin
      if (sck_r) begin
        in_sh <= shift_byte[W-2:0];
        cnt   <= last ? '0 : cnt + 1'b1;
      end
      if (last && st == ST_OPC)
        st <= (shift_byte == OP_WR) ? ST_WR :
              (shift_byte == OP_RD) ? ST_RD : ST_IGN;
      if (last && st == ST_WR && tx_full)
        ovf <= 1'b1;
      if (go_rd) begin
        out_sh <= rx_empty ? '0 : rx_data;
        if (rx_empty) udf <= 1'b1;
      end
      if (sck_f) begin
        if (st == ST_RD) begin
          sdo    <= out_sh[W-1];
          out_sh <= out_sh << 1;
        end else begin
          sdo <= 1'b0;
        end
      end
    end

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $past(tx_full));
  // R5
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) udf |=> udf);
  // R5
  udf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(udf) |-> $past(rx_empty));
  // R4
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sck_f) || $past(!sel)));
  // R6
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !sel |=> !sdo);
  // R7
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IGN) |-> !sdo);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({tx_push, rx_pop}));
endmodule

// File: tb/sim_spi_fifo_port.sv
`timescale 1ns/1ps
module sim_spi_fifo_port;
  localparam int CAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, tx_push, rx_pop, ovf, udf;
  logic [7:0] tx_data;
  logic tx_full = 1'b0, rx_empty = 1'b1;
  logic [7:0] rx_data = 8'h00;

  always #5 clk = ~clk;

  spi_fifo_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .ovf(ovf), .udf(udf)
  );

  int n_chk = 0, n_bad = 0;
  bit run = 0, done = 0;
  logic nx_sclk = 1'b0, nx_cs = 1'b1, nx_sdi = 1'b0;
  logic [2:0] hist[$];
  logic [7:0] txq[$], rxq[$], log_q[$];
  bit e_push = 0, e_pop = 0;
  logic [7:0] e_data = 8'h00;

  int m_mode = 0, m_cnt = 0, m_acc = 0, m_out = 0;
  bit m_sdo = 0, m_ovf = 0, m_udf = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  initial begin
    hist.push_back(3'b010);
    hist.push_back(3'b010);
    hist.push_back(3'b010);
  end

  // cycle model: modes 0 opcode, 1 write, 2 read, 3 ignore
  always @(negedge clk) begin : mdl
    logic [2:0] h2, h3;
    bit s_on, rise, fall, lst, ep, epop, gord;
    int bval, old_mode;
    if (run) begin
      h2 = hist[hist.size()-2];
      h3 = hist[hist.size()-3];
      s_on = !h2[1];
      rise = h2[2] && !h3[2];
      fall = !h2[2] && h3[2];
      bval = ((m_acc << 1) | int'(h2[0])) & 255;
      lst  = s_on && rise && (m_cnt == 7);
      ep   = lst && m_mode == 1 && !tx_full;
      gord = lst && ((m_mode == 0 && bval == 'h77) || m_mode == 2);
      epop = gord && !rx_empty;
      chk(tx_push == ep, "R2 push", tx_push, ep);
      if (ep) chk(tx_data == bval[7:0], "R1 data", tx_data, bval);
      chk(rx_pop == epop, "R4 pop", rx_pop, epop);
      chk(sdo == m_sdo, "R4 sdo", sdo, m_sdo);
      chk(ovf == m_ovf, "R3 ovf", ovf, m_ovf);
      chk(udf == m_udf, "R5 udf", udf, m_udf);
      if (tx_push) log_q.push_back(tx_data);
      e_push = ep; e_pop = epop; e_data = bval[7:0];
      old_mode = m_mode;
      if (!s_on) begin
        m_mode = 0; m_cnt = 0; m_sdo = 0;
      end else begin
        if (rise) begin
          m_acc = bval;
          m_cnt = lst ? 0 : m_cnt + 1;
          if (lst && old_mode == 0)
            m_mode = (bval == 'h66) ? 1 : (bval == 'h77) ? 2 : 3;
          if (lst && old_mode == 1 && tx_full) m_ovf = 1;
          if (gord) begin
            m_out = rx_empty ? 0 : int'(rx_data);
            if (rx_empty) m_udf = 1;
          end
        end
        if (fall) begin
          if (m_mode == 2) begin
            m_sdo = m_out[7];
            m_out = (m_out << 1) & 255;
          end else m_sdo = 0;
        end
      end
    end
    sclk <= nx_sclk; cs_n <= nx_cs; sdi <= nx_sdi;
    hist.push_back({nx_sclk, nx_cs, nx_sdi});
    if (hist.size() > 5) void'(hist.pop_front());
  end

  // external FIFOs
  always @(posedge clk) begin
    #1;
    if (e_push) txq.push_back(e_data);
    if (e_pop && rxq.size() > 0) void'(rxq.pop_front());
    e_push = 0; e_pop = 0;
    tx_full  = (txq.size() >= CAP);
    rx_empty = (rxq.size() == 0);
    rx_data  = rxq.size() > 0 ? rxq[0] : 8'h00;
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      nx_sdi = b[i];
      tick(4);
      nx_sclk = 1'b1;
      r[i] = sdo;
      tick(4);
      nx_sclk = 1'b0;
    end
  endtask

  task automatic cs_on;  nx_cs = 1'b0; tick(4); endtask
  task automatic cs_off; tick(4); nx_cs = 1'b1; tick(8); endtask

  task automatic write_burst(input logic [7:0] d[$]);
    logic [7:0] r;
    cs_on();
    xfer(8'h66, r);
    foreach (d[i]) xfer(d[i], r);
    cs_off();
  endtask

  initial begin
    logic [7:0] r, a, b;
    int base;
    tick(6);
    rst_n = 1'b1;
    run = 1;
    tick(2);
    // R8 reset state
    chk({sdo, tx_push, rx_pop, ovf, udf} == 5'b0, "R8 reset", {sdo, tx_push, rx_pop, ovf, udf}, 0);

    // R2 / R1 write burst
    write_burst('{8'h12, 8'hC3, 8'hF0});
    chk(log_q.size() == 3, "R2 count", log_q.size(), 3);
    chk(log_q.size() == 3 && log_q[0] == 8'h12 && log_q[1] == 8'hC3 && log_q[2] == 8'hF0,
        "R1 bytes msb first", log_q.size() > 0 ? log_q[0] : 0, 'h12);

    // R3 overflow
    write_burst('{8'h01, 8'h02, 8'h03});
    chk(txq.size() == CAP, "R3 fifo level", txq.size(), CAP);
    chk(log_q.size() == 4 && log_q[3] == 8'h01, "R3 only first kept", log_q.size(), 4);
    chk(ovf == 1'b1, "R3 ovf sticky", ovf, 1);

    // R6 partial byte then new transaction
    txq.delete(); log_q.delete();
    tick(2);
    cs_on();
    xfer(8'h66, r);
    for (int i = 0; i < 5; i++) begin
      nx_sdi = i[0]; tick(4); nx_sclk = 1'b1; tick(4); nx_sclk = 1'b0;
    end
    cs_off();
    chk(log_q.size() == 0, "R6 partial dropped", log_q.size(), 0);
    chk(sdo == 1'b0, "R6 sdo idle", sdo, 0);
    write_burst('{8'hAB});
    chk(log_q.size() == 1 && log_q[0] == 8'hAB, "R6 fresh opcode", log_q.size(), 1);

    // R4 / R9 read
    rxq = '{8'h3C, 8'hA5, 8'h81, 8'h7E};
    tick(2);
    cs_on();
    xfer(8'h77, r);
    xfer(8'h00, a);
    xfer(8'h00, b);
    cs_off();
    chk(a == 8'h3C, "R4 read byte 0", a, 'h3C);
    chk(b == 8'hA5, "R4 read byte 1", b, 'hA5);
    chk(rxq.size() == 1, "R9 pops N+1", rxq.size(), 1);
    chk(udf == 1'b0, "R5 no underflow yet", udf, 0);

    // R5 underflow
    cs_on();
    xfer(8'h77, r);
    xfer(8'h00, a);
    xfer(8'h00, b);
    cs_off();
    chk(a == 8'h7E, "R5 last real byte", a, 'h7E);
    chk(b == 8'h00, "R5 empty gives zero", b, 0);
    chk(udf == 1'b1, "R5 udf set", udf, 1);

    // R7 unknown opcode
    rxq = '{8'hFF};
    base = log_q.size();
    tick(2);
    cs_on();
    xfer(8'h5A, r);
    xfer(8'h66, a);
    xfer(8'h77, b);
    cs_off();
    chk(a == 8'h00 && b == 8'h00, "R7 sdo zero", {a, b}, 0);
    chk(rxq.size() == 1, "R7 no pop", rxq.size(), 1);
    chk(log_q.size() == base, "R7 no push", log_q.size(), base);

    // R6 release coincident with final rising edge
    txq.delete(); log_q.delete();
    tick(2);
    cs_on();
    xfer(8'h66, r);
    xfer(8'h99, r);
    for (int i = 7; i >= 1; i--) begin
      nx_sdi = i[0]; tick(4); nx_sclk = 1'b1; tick(4); nx_sclk = 1'b0;
    end
    nx_sdi = 1'b1; tick(4);
    nx_sclk = 1'b1; nx_cs = 1'b1;
    tick(4);
    nx_sclk = 1'b0;
    tick(8);
    chk(log_q.size() == 1 && log_q[0] == 8'h99, "R6 release wins", log_q.size(), 1);

    tick(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule